// File: doc/BRIEF.md
# DRAM System Address Channel Decoder

This block turns a physical system address into a DRAM channel number and a normalized address within that channel, for one node of a multi-node memory system. Together with the address it receives the node's decode settings: the DRAM range bounds and node-interleave selector, the memory hole below 4 GiB, an optional swapped low region, and the channel-select controls (ganging, a high address range steered to a fixed channel, and four channel-interleave modes).

Each strobed request is decoded combinationally and registered, so the result appears one cycle later with a matching valid pulse. A request that falls outside the node's range, lands in the memory hole, or comes with an illegal node-interleave mask reports a miss with zeroed channel and address fields. Chip-select lookup and register programming sit outside this block.

Top module: `dram_chan_decoder`

## Requirements
- R1: A request hits the node only when `rng_en` is nonzero, the address lies in {rng_base,24'h000000} through {rng_limit,24'hFFFFFF} inclusive, and either `node_mask` is 0 or `node_id` equals address bits [14:12] ANDed with `node_mask`; otherwise `out_hit` is 0.
- R2: With `hole_en` set, an address at or above {hole_base,24'h0} and below 4 GiB gives `out_hit` = 0 even if R1 holds.
- R3: With `swap_en` set and address bits [47:34] all zero, if bits [33:27] lie in `swap_base`..`swap_limit` inclusive or are below `swap_size`, the address is XORed with `swap_base` shifted left by 27 before channel selection and offset removal.
- R4: The high range is selected when `hi_rng_en` is 1, `gang_en` is 0 and the (swapped) address is at least {sel_base,27'h0}; then `out_chan` equals `hi_chan`, overriding every interleave mode.
- R5: With `gang_en` set, `out_chan` is address bit 3, with priority over all other channel rules.
- R6: With `ilv_en` set and no high range, `ilv_mode` 0 picks address bit 6 and `ilv_mode` 1 picks address bit 12+L, where L is 0, 1, 2, 3 for `node_mask` 0, 1, 3, 7.
- R7: `ilv_mode` 2 picks XOR of address bits [20:16] and bit 6; `ilv_mode` 3 picks XOR of bits [20:16] and bit 9.
- R8: With no gang, no high range and no interleave, `out_chan` is the inverse of `hi_chan` when `hi_rng_en` is 1, else 0.
- R9: The subtracted offset is {hole_ofs,23'h0} when the hole is enabled, the address is at least 4 GiB and (in the high range) {sel_base,27'h0} is below {hole_base,24'h0}; otherwise {sel_ofs,26'h0} in the high range and {rng_base,24'h0} outside it.
- R10: After offset removal, L address bits starting at bit 12 are removed; bits [11:0] pass unchanged and higher bits shift down by L.
- R11: When `ilv_en` is 1, gang is off and the high range is not selected, one more bit is removed: bit 6 for `ilv_mode` 0 or 2, bit 12 for mode 1, bit 9 for mode 3.
- R12: A `node_mask` other than 0, 1, 3 or 7 sets `out_cfg_err` and forces `out_hit` to 0.
- R13: Outputs update one cycle after `in_valid` with `out_valid` high for that cycle only; on a miss `out_chan` and `out_chan_addr` are 0; without `in_valid` all result outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| sys_addr | input | 48 | Physical system address |
| rng_en | input | 2 | Node range enable field (nonzero enables) |
| rng_base | input | 24 | Range base, address bits [47:24] |
| rng_limit | input | 24 | Range limit, address bits [47:24] |
| node_mask | input | 3 | Node-interleave bit mask |
| node_id | input | 3 | Node-interleave selector value |
| hole_en | input | 1 | Memory hole valid |
| hole_base | input | 8 | Hole base, address bits [31:24] |
| hole_ofs | input | 9 | Hole offset, address bits [31:23] |
| swap_en | input | 1 | Swapped region enable |
| swap_base | input | 7 | Swapped region base, 128 MiB units |
| swap_limit | input | 7 | Swapped region limit, 128 MiB units |
| swap_size | input | 7 | Swapped region size, 128 MiB units |
| hi_rng_en | input | 1 | High channel range enable |
| hi_chan | input | 1 | Channel for the high range |
| ilv_en | input | 1 | Channel interleave enable |
| gang_en | input | 1 | Ganged channels |
| ilv_mode | input | 2 | Channel interleave mode |
| sel_base | input | 21 | High range base, address bits [47:27] |
| sel_ofs | input | 22 | High range offset, address bits [47:26] |
| out_valid | output | 1 | Result strobe |
| out_hit | output | 1 | Address maps to DRAM of this node |
| out_cfg_err | output | 1 | Illegal node-interleave mask |
| out_chan | output | 1 | Selected channel |
| out_chan_addr | output | 48 | Normalized channel address |

## Verification
The bench targets the range edges (exact limit, one below the base, disabled range), the hole boundary at its base and just under 4 GiB, where a wrong comparison would hand out a channel address for memory that does not exist. It drives each channel-select rule including the hash modes and the gang-over-high-range priority, so a reordered priority chain shows up as a wrong channel. Combined node and channel interleave vectors catch bit removal done in the wrong order or at the wrong position, which would shift the channel address by a power of two, and the hole-plus-high-range case catches the wrong offset being subtracted.

// File: rtl/dcd_pkg.sv
`timescale 1ns/1ps
package dcd_pkg;
  localparam int AW           = 48;
  localparam int RNG_GRAN     = 24;
  localparam int RNG_FW       = AW - RNG_GRAN;
  localparam int HOLE_BASE_SH = 24;
  localparam int HOLE_BASE_FW = 32 - HOLE_BASE_SH;
  localparam int HOLE_OFS_SH  = 23;
  localparam int HOLE_OFS_FW  = 32 - HOLE_OFS_SH;
  localparam int SEL_BASE_SH  = 27;
  localparam int SEL_BASE_FW  = AW - SEL_BASE_SH;
  localparam int SEL_OFS_SH   = 26;
  localparam int SEL_OFS_FW   = AW - SEL_OFS_SH;
  localparam int SWAP_SH      = 27;
  localparam int SWAP_TOP     = 34;
  localparam int SWAP_FW      = SWAP_TOP - SWAP_SH;
  localparam int NODE_SH      = 12;
  localparam int NODE_FW      = 3;
  localparam int HASH_LO      = 16;
  localparam int HASH_HI      = 20;

  typedef logic [AW-1:0] addr_t;
  localparam addr_t FOUR_GIB = addr_t'(64'h1_0000_0000);

  typedef enum logic [2:0] {
    SRC_ZERO, SRC_GANG, SRC_HIGH, SRC_BIT6, SRC_HASH, SRC_NODE_NEXT, SRC_HI_INV
  } chan_src_e;

  function automatic logic mask_legal(input logic [NODE_FW-1:0] m);
    return (m == 3'b000) || (m == 3'b001) || (m == 3'b011) || (m == 3'b111);
  endfunction

  function automatic logic [1:0] ilog_of(input logic [NODE_FW-1:0] m);
    case (m)
      3'b001:  return 2'd1;
      3'b011:  return 2'd2;
      3'b111:  return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic addr_t drop_bit(input addr_t a, input int unsigned pos);
    addr_t keep_lo;
    keep_lo = (addr_t'(1) << pos) - addr_t'(1);
    return ((a >> (pos + 1)) << pos) | (a & keep_lo);
  endfunction

  function automatic addr_t drop_node_bits(input addr_t a, input logic [1:0] n);
    addr_t keep_lo;
    keep_lo = (addr_t'(1) << NODE_SH) - addr_t'(1);
    return ((a >> (NODE_SH + int'(n))) << NODE_SH) | (a & keep_lo);
  endfunction

  function automatic logic hash5(input addr_t a);
    return ^a[HASH_HI:HASH_LO];
  endfunction
endpackage

// File: rtl/dcd_range_check.sv
`timescale 1ns/1ps
module dcd_range_check
  import dcd_pkg::*;
(
  input  addr_t                   addr,
  input  logic [1:0]              rng_en,
  input  logic [RNG_FW-1:0]       rng_base,
  input  logic [RNG_FW-1:0]       rng_limit,
  input  logic [NODE_FW-1:0]      node_mask,
  input  logic [NODE_FW-1:0]      node_id,
  input  logic                    hole_en,
  input  logic [HOLE_BASE_FW-1:0] hole_base,
  output logic                    range_hit,
  output logic                    hole_hit,
  output logic                    cfg_err,
  output logic [1:0]              ilog
);
  addr_t base_full, limit_full, hole_full;
  logic  node_ok;

  always_comb begin
    base_full  = {rng_base,  {RNG_GRAN{1'b0}}};
    limit_full = {rng_limit, {RNG_GRAN{1'b1}}};
    hole_full  = addr_t'({hole_base, {HOLE_BASE_SH{1'b0}}});
    node_ok    = (node_mask == '0) ||
                 (node_id == (addr[NODE_SH+NODE_FW-1:NODE_SH] & node_mask));
    range_hit  = (rng_en != '0) && (addr >= base_full) && (addr <= limit_full) && node_ok;
    hole_hit   = hole_en && (addr >= hole_full) && (addr < FOUR_GIB);
    cfg_err    = !mask_legal(node_mask);
    ilog       = ilog_of(node_mask);
  end
endmodule

// File: rtl/dcd_region_swap.sv
`timescale 1ns/1ps
module dcd_region_swap
  import dcd_pkg::*;
(
  input  addr_t              addr_in,
  input  logic               swap_en,
  input  logic [SWAP_FW-1:0] swap_base,
  input  logic [SWAP_FW-1:0] swap_limit,
  input  logic [SWAP_FW-1:0] swap_size,
  output addr_t              addr_out
);
  logic [SWAP_FW-1:0] blk;
  logic               low_16g, in_region;

  always_comb begin
    blk       = addr_in[SWAP_TOP-1:SWAP_SH];
    low_16g   = (addr_in[AW-1:SWAP_TOP] == '0);
    in_region = low_16g && (((blk >= swap_base) && (blk <= swap_limit)) || (blk < swap_size));
    addr_out  = (swap_en && in_region) ?
                (addr_in ^ addr_t'({swap_base, {SWAP_SH{1'b0}}})) : addr_in;
  end
endmodule

// File: rtl/dcd_chan_select.sv
`timescale 1ns/1ps
module dcd_chan_select
  import dcd_pkg::*;
(
  input  addr_t                  addr,
  input  logic [1:0]             ilog,
  input  logic                   hi_rng_en,
  input  logic                   hi_chan,
  input  logic                   ilv_en,
  input  logic                   gang_en,
  input  logic [1:0]             ilv_mode,
  input  logic [SEL_BASE_FW-1:0] sel_base,
  output logic                   hi_sel,
  output logic                   chan
);
  chan_src_e src;

  always_comb begin
    hi_sel = hi_rng_en && !gang_en && (addr >= {sel_base, {SEL_BASE_SH{1'b0}}});
    if (gang_en)                    src = SRC_GANG;
    else if (hi_sel)                src = SRC_HIGH;
    else if (ilv_en && ilv_mode == 2'd0) src = SRC_BIT6;
    else if (ilv_en && ilv_mode[1]) src = SRC_HASH;
    else if (ilv_en)                src = SRC_NODE_NEXT;
    else if (hi_rng_en)             src = SRC_HI_INV;
    else                            src = SRC_ZERO;
  end

  always_comb begin
    case (src)
      SRC_GANG:      chan = addr[3];
      SRC_HIGH:      chan = hi_chan;
      SRC_BIT6:      chan = addr[6];
      SRC_HASH:      chan = hash5(addr) ^ (ilv_mode[0] ? addr[9] : addr[6]);
      SRC_NODE_NEXT: chan = addr[NODE_SH + int'(ilog)];
      SRC_HI_INV:    chan = ~hi_chan;
      default:       chan = 1'b0;
    endcase
  end
endmodule

// File: rtl/dcd_addr_norm.sv
`timescale 1ns/1ps
module dcd_addr_norm
  import dcd_pkg::*;
(
  input  addr_t                   addr,
  input  logic                    hi_sel,
  input  logic                    hole_en,
  input  logic [HOLE_BASE_FW-1:0] hole_base,
  input  logic [HOLE_OFS_FW-1:0]  hole_ofs,
  input  logic [SEL_BASE_FW-1:0]  sel_base,
  input  logic [SEL_OFS_FW-1:0]   sel_ofs,
  input  logic [RNG_FW-1:0]       rng_base,
  input  logic [1:0]              ilog,
  input  logic                    ilv_en,
  input  logic                    gang_en,
  input  logic [1:0]              ilv_mode,
  output addr_t                   chan_addr
);
  addr_t hole_base_full, hole_ofs_full, sel_base_full, sel_ofs_full, rng_base_full;
  addr_t offset, rebased, node_free;
  logic  hole_applies;

  always_comb begin
    hole_base_full = addr_t'({hole_base, {HOLE_BASE_SH{1'b0}}});
    hole_ofs_full  = addr_t'({hole_ofs,  {HOLE_OFS_SH{1'b0}}});
    sel_base_full  = {sel_base, {SEL_BASE_SH{1'b0}}};
    sel_ofs_full   = {sel_ofs,  {SEL_OFS_SH{1'b0}}};
    rng_base_full  = {rng_base, {RNG_GRAN{1'b0}}};
    hole_applies   = hole_en && (addr >= FOUR_GIB);
    if (hi_sel)
      offset = (hole_applies && (sel_base_full < hole_base_full)) ? hole_ofs_full : sel_ofs_full;
    else
      offset = hole_applies ? hole_ofs_full : rng_base_full;
    rebased   = addr - offset;
    node_free = drop_node_bits(rebased, ilog);
    if (ilv_en && !hi_sel && !gang_en) begin
      if (!ilv_mode[0])          chan_addr = drop_bit(node_free, 6);
      else if (ilv_mode == 2'd1) chan_addr = drop_bit(node_free, 12);
      else                       chan_addr = drop_bit(node_free, 9);
    end else begin
      chan_addr = node_free;
    end
  end
endmodule

// File: rtl/dram_chan_decoder.sv
`timescale 1ns/1ps
module dram_chan_decoder
  import dcd_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [AW-1:0]           sys_addr,
  input  logic [1:0]              rng_en,
  input  logic [RNG_FW-1:0]       rng_base,
  input  logic [RNG_FW-1:0]       rng_limit,
  input  logic [NODE_FW-1:0]      node_mask,
  input  logic [NODE_FW-1:0]      node_id,
  input  logic                    hole_en,
  input  logic [HOLE_BASE_FW-1:0] hole_base,
  input  logic [HOLE_OFS_FW-1:0]  hole_ofs,
  input  logic                    swap_en,
  input  logic [SWAP_FW-1:0]      swap_base,
  input  logic [SWAP_FW-1:0]      swap_limit,
  input  logic [SWAP_FW-1:0]      swap_size,
  input  logic                    hi_rng_en,
  input  logic                    hi_chan,
  input  logic                    ilv_en,
  input  logic                    gang_en,
  input  logic [1:0]              ilv_mode,
  input  logic [SEL_BASE_FW-1:0]  sel_base,
  input  logic [SEL_OFS_FW-1:0]   sel_ofs,
  output logic                    out_valid,
  output logic                    out_hit,
  output logic                    out_cfg_err,
  output logic                    out_chan,
  output logic [AW-1:0]           out_chan_addr
);
  logic       range_hit, hole_hit, cfg_err, hi_sel, chan, hit;
  logic [1:0] ilog;
  addr_t      swapped, chan_addr;

  dcd_range_check u_range (
    .addr(sys_addr), .rng_en(rng_en), .rng_base(rng_base), .rng_limit(rng_limit),
    .node_mask(node_mask), .node_id(node_id), .hole_en(hole_en), .hole_base(hole_base),
    .range_hit(range_hit), .hole_hit(hole_hit), .cfg_err(cfg_err), .ilog(ilog)
  );

  dcd_region_swap u_swap (
    .addr_in(sys_addr), .swap_en(swap_en), .swap_base(swap_base),
    .swap_limit(swap_limit), .swap_size(swap_size), .addr_out(swapped)
  );

  dcd_chan_select u_csel (
    .addr(swapped), .ilog(ilog), .hi_rng_en(hi_rng_en), .hi_chan(hi_chan),
    .ilv_en(ilv_en), .gang_en(gang_en), .ilv_mode(ilv_mode), .sel_base(sel_base),
    .hi_sel(hi_sel), .chan(chan)
  );

  dcd_addr_norm u_norm (
    .addr(swapped), .hi_sel(hi_sel), .hole_en(hole_en), .hole_base(hole_base),
    .hole_ofs(hole_ofs), .sel_base(sel_base), .sel_ofs(sel_ofs), .rng_base(rng_base),
    .ilog(ilog), .ilv_en(ilv_en), .gang_en(gang_en), .ilv_mode(ilv_mode),
    .chan_addr(chan_addr)
  );

  assign hit = range_hit && !hole_hit && !cfg_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_hit       <= 1'b0;
      out_cfg_err   <= 1'b0;
      out_chan      <= 1'b0;
      out_chan_addr <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_hit       <= hit;
        out_cfg_err   <= cfg_err;
        out_chan      <= hit ? chan : 1'b0;
        out_chan_addr <= hit ? chan_addr : '0;
      end
    end
  end
endmodule

// File: rtl/dcd_checker.sv
`timescale 1ns/1ps
module dcd_checker
  import dcd_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                addr_b3,
  input logic [NODE_FW-1:0]  node_mask,
  input logic                gang_en,
  input logic                hi_rng_en,
  input logic                hi_chan,
  input logic                range_hit,
  input logic                hole_hit,
  input logic                hi_sel,
  input logic                out_valid,
  input logic                out_hit,
  input logic                out_cfg_err,
  input logic                out_chan,
  input logic [AW-1:0]       out_chan_addr
);
  AST_RANGE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !range_hit |=> !out_hit); // R1
  AST_HOLE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && hole_hit |=> !out_hit); // R2
  AST_HI_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && hi_sel |=> !out_hit || (out_chan == $past(hi_chan))); // R4
  AST_HI_UNGANGED: assert property (@(posedge clk) disable iff (!rst_n)
    hi_sel |-> hi_rng_en && !gang_en); // R4
  AST_GANG_BIT3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && gang_en |=> !out_hit || (out_chan == $past(addr_b3))); // R5
  AST_BAD_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !((node_mask == 3'd0) || (node_mask == 3'd1) || (node_mask == 3'd3) ||
                  (node_mask == 3'd7)) |=> out_cfg_err && !out_hit); // R12
  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R13
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R13
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_hit) && $stable(out_chan) && $stable(out_chan_addr) &&
                  $stable(out_cfg_err)); // R13
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_hit |-> !out_chan && (out_chan_addr == '0)); // R13
endmodule

bind dram_chan_decoder dcd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .addr_b3(sys_addr[3]),
  .node_mask(node_mask), .gang_en(gang_en), .hi_rng_en(hi_rng_en), .hi_chan(hi_chan),
  .range_hit(range_hit), .hole_hit(hole_hit), .hi_sel(hi_sel),
  .out_valid(out_valid), .out_hit(out_hit), .out_cfg_err(out_cfg_err),
  .out_chan(out_chan), .out_chan_addr(out_chan_addr)
);

// File: tb/dram_chan_decoder_tb.sv
`timescale 1ns/1ps
module dram_chan_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [47:0] sys_addr = '0;
  logic [1:0]  rng_en;
  logic [23:0] rng_base, rng_limit;
  logic [2:0]  node_mask, node_id;
  logic        hole_en;
  logic [7:0]  hole_base;
  logic [8:0]  hole_ofs;
  logic        swap_en;
  logic [6:0]  swap_base, swap_limit, swap_size;
  logic        hi_rng_en, hi_chan, ilv_en, gang_en;
  logic [1:0]  ilv_mode;
  logic [20:0] sel_base;
  logic [21:0] sel_ofs;
  logic        out_valid, out_hit, out_cfg_err, out_chan;
  logic [47:0] out_chan_addr;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dram_chan_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sys_addr(sys_addr),
    .rng_en(rng_en), .rng_base(rng_base), .rng_limit(rng_limit),
    .node_mask(node_mask), .node_id(node_id), .hole_en(hole_en),
    .hole_base(hole_base), .hole_ofs(hole_ofs), .swap_en(swap_en),
    .swap_base(swap_base), .swap_limit(swap_limit), .swap_size(swap_size),
    .hi_rng_en(hi_rng_en), .hi_chan(hi_chan), .ilv_en(ilv_en), .gang_en(gang_en),
    .ilv_mode(ilv_mode), .sel_base(sel_base), .sel_ofs(sel_ofs),
    .out_valid(out_valid), .out_hit(out_hit), .out_cfg_err(out_cfg_err),
    .out_chan(out_chan), .out_chan_addr(out_chan_addr)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [4:0]  preset;
    logic [47:0] addr;
    logic        hit;
    logic        err;
    logic        chan;
    logic [47:0] caddr;
  } vec_t;

  localparam int NV = 41;
  localparam vec_t VECS [NV] = '{
    // P0 plain range, R1
    '{4'd1, 5'd0,  48'h0000_1234_5678, 1'b1, 1'b0, 1'b0, 48'h0000_1234_5678},
    '{4'd1, 5'd0,  48'h00FF_FFFF_FFFF, 1'b1, 1'b0, 1'b0, 48'h00FF_FFFF_FFFF},
    '{4'd1, 5'd0,  48'h0100_0000_0000, 1'b0, 1'b0, 1'b0, 48'h0},
    // P1 ganged, R5
    '{4'd5, 5'd1,  48'h8,              1'b1, 1'b0, 1'b1, 48'h8},
    '{4'd5, 5'd1,  48'h7,              1'b1, 1'b0, 1'b0, 48'h7},
    // P2 interleave mode 0, R6 and R11
    '{4'd6, 5'd2,  48'h40,             1'b1, 1'b0, 1'b1, 48'h0},
    '{4'd11,5'd2,  48'h1C5,            1'b1, 1'b0, 1'b1, 48'hC5},
    '{4'd11,5'd2,  48'h185,            1'b1, 1'b0, 1'b0, 48'hC5},
    // P3 interleave mode 1, R6
    '{4'd6, 5'd3,  48'h1ABC,           1'b1, 1'b0, 1'b1, 48'hABC},
    '{4'd6, 5'd3,  48'h2ABC,           1'b1, 1'b0, 1'b0, 48'h1ABC},
    // P4 hash with bit 6, R7
    '{4'd7, 5'd4,  48'h1_0000,         1'b1, 1'b0, 1'b1, 48'h8000},
    '{4'd7, 5'd4,  48'h3_0040,         1'b1, 1'b0, 1'b1, 48'h1_8000},
    // P5 hash with bit 9, R7
    '{4'd7, 5'd5,  48'h1_0200,         1'b1, 1'b0, 1'b0, 48'h8000},
    '{4'd7, 5'd5,  48'h240,            1'b1, 1'b0, 1'b1, 48'h40},
    // P6 high range, R4 R8 R9
    '{4'd4, 5'd6,  48'h1000_0000,      1'b1, 1'b0, 1'b1, 48'h0},
    '{4'd8, 5'd6,  48'h0FFF_FFFF,      1'b1, 1'b0, 1'b0, 48'h0FFF_FFFF},
    '{4'd9, 5'd6,  48'h2345_6789,      1'b1, 1'b0, 1'b1, 48'h1345_6789},
    // P7 hole, R2 R9
    '{4'd2, 5'd7,  48'hC000_0000,      1'b0, 1'b0, 1'b0, 48'h0},
    '{4'd2, 5'd7,  48'hFFFF_FFFF,      1'b0, 1'b0, 1'b0, 48'h0},
    '{4'd2, 5'd7,  48'hBFFF_FFFF,      1'b1, 1'b0, 1'b0, 48'hBFFF_FFFF},
    '{4'd9, 5'd7,  48'h1_0000_0000,    1'b1, 1'b0, 1'b0, 48'hC000_0000},
    // P8 node interleave, R1 R10
    '{4'd10,5'd8,  48'h1234,           1'b1, 1'b0, 1'b0, 48'h234},
    '{4'd10,5'd8,  48'h3234,           1'b1, 1'b0, 1'b0, 48'h1234},
    '{4'd1, 5'd8,  48'h2234,           1'b0, 1'b0, 1'b0, 48'h0},
    // P9 region swap, R3
    '{4'd3, 5'd9,  48'h0800_0000,      1'b1, 1'b0, 1'b0, 48'h0},
    '{4'd3, 5'd9,  48'h100,            1'b1, 1'b0, 1'b0, 48'h0800_0100},
    '{4'd3, 5'd9,  48'h1000_0000,      1'b1, 1'b0, 1'b0, 48'h1000_0000},
    '{4'd3, 5'd9,  48'h4_0800_0000,    1'b1, 1'b0, 1'b0, 48'h4_0800_0000},
    // P10 disabled range, R1
    '{4'd1, 5'd10, 48'h1000,           1'b0, 1'b0, 1'b0, 48'h0},
    // P11 base at 4 GiB, R1 R9
    '{4'd1, 5'd11, 48'hFFFF_FFFF,      1'b0, 1'b0, 1'b0, 48'h0},
    '{4'd9, 5'd11, 48'h1_0000_0000,    1'b1, 1'b0, 1'b0, 48'h0},
    '{4'd9, 5'd11, 48'h1_0000_1000,    1'b1, 1'b0, 1'b0, 48'h1000},
    // P12 illegal mask, R12
    '{4'd12,5'd12, 48'h0,              1'b0, 1'b1, 1'b0, 48'h0},
    // P13 gang beats high range, R5
    '{4'd5, 5'd13, 48'h2000_0008,      1'b1, 1'b0, 1'b1, 48'h2000_0008},
    '{4'd5, 5'd13, 48'h2000_0000,      1'b1, 1'b0, 1'b0, 48'h2000_0000},
    // P14 high range with hole, R9
    '{4'd9, 5'd14, 48'h1_0000_0000,    1'b1, 1'b0, 1'b1, 48'hC000_0000},
    '{4'd9, 5'd14, 48'h2000_0000,      1'b1, 1'b0, 1'b1, 48'h1000_0000},
    '{4'd2, 5'd14, 48'hC000_0000,      1'b0, 1'b0, 1'b0, 48'h0},
    // P15 node plus channel interleave, R6 R10 R11
    '{4'd11,5'd15, 48'h2000,           1'b1, 1'b0, 1'b1, 48'h0},
    '{4'd11,5'd15, 48'h6000,           1'b1, 1'b0, 1'b1, 48'h1000},
    '{4'd10,5'd15, 48'h4000,           1'b1, 1'b0, 1'b0, 48'h1000}
  };

  task automatic load_preset(input int p);
    rng_en = 2'b01; rng_base = '0; rng_limit = 24'h00FFFF;
    node_mask = '0; node_id = '0;
    hole_en = 1'b0; hole_base = '0; hole_ofs = '0;
    swap_en = 1'b0; swap_base = '0; swap_limit = '0; swap_size = '0;
    hi_rng_en = 1'b0; hi_chan = 1'b0; ilv_en = 1'b0; gang_en = 1'b0;
    ilv_mode = '0; sel_base = '0; sel_ofs = '0;
    case (p)
      1:  gang_en = 1'b1;
      2:  begin ilv_en = 1'b1; ilv_mode = 2'd0; end
      3:  begin ilv_en = 1'b1; ilv_mode = 2'd1; end
      4:  begin ilv_en = 1'b1; ilv_mode = 2'd2; end
      5:  begin ilv_en = 1'b1; ilv_mode = 2'd3; end
      6:  begin hi_rng_en = 1'b1; hi_chan = 1'b1; sel_base = 21'd2; sel_ofs = 22'd4; end
      7:  begin hole_en = 1'b1; hole_base = 8'hC0; hole_ofs = 9'h080; end
      8:  begin node_mask = 3'b001; node_id = 3'd1; end
      9:  begin swap_en = 1'b1; swap_base = 7'd1; swap_limit = 7'd1; swap_size = 7'd1; end
      10: rng_en = 2'b00;
      11: rng_base = 24'h000100;
      12: node_mask = 3'b010;
      13: begin gang_en = 1'b1; hi_rng_en = 1'b1; hi_chan = 1'b1; sel_base = 21'd2; end
      14: begin hi_rng_en = 1'b1; hi_chan = 1'b1; sel_base = 21'd2; sel_ofs = 22'd4;
                hole_en = 1'b1; hole_base = 8'hC0; hole_ofs = 9'h080; end
      15: begin node_mask = 3'b001; node_id = 3'd0; ilv_en = 1'b1; ilv_mode = 2'd1; end
      default: ;
    endcase
  endtask

  task automatic check_bit(input string req, input string what, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic check_addr(input string req, input string what, input logic [47:0] act,
                            input logic [47:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    string rq;
    rq = $sformatf("R%0d vec%0d", v.req, idx);
    @(negedge clk);
    load_preset(int'(v.preset));
    sys_addr = v.addr;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    n_tests++;
    if (out_valid !== 1'b1 || out_hit !== v.hit || out_cfg_err !== v.err ||
        out_chan !== v.chan || out_chan_addr !== v.caddr) begin
      n_fail++;
      $display("FAIL %s: actual v=%0b hit=%0b err=%0b ch=%0b ca=%h expected v=1 hit=%0b err=%0b ch=%0b ca=%h",
               rq, out_valid, out_hit, out_cfg_err, out_chan, out_chan_addr,
               v.hit, v.err, v.chan, v.caddr);
    end
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [47:0] held;
    load_preset(0);
    repeat (3) @(negedge clk);
    // R13 reset state
    check_bit("R13", "reset out_valid", out_valid, 1'b0);
    check_bit("R13", "reset out_hit", out_hit, 1'b0);
    check_addr("R13", "reset out_chan_addr", out_chan_addr, 48'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R13 hold while idle: last vector left a hit with address 0x1000
    held = out_chan_addr;
    @(negedge clk);
    check_bit("R13", "idle out_valid", out_valid, 1'b0);
    sys_addr = 48'h0000_0000_0040;
    load_preset(2);
    repeat (3) @(negedge clk);
    check_addr("R13", "idle hold chan_addr", out_chan_addr, held);
    check_bit("R13", "idle hold hit", out_hit, 1'b1);
    check_bit("R13", "idle valid low", out_valid, 1'b0);

    // R13 back-to-back requests: result follows each strobe by one cycle
    @(negedge clk);
    load_preset(1);
    sys_addr = 48'h8;
    in_valid = 1'b1;
    @(negedge clk);
    check_bit("R5", "b2b first chan", out_chan, 1'b1);
    sys_addr = 48'h10;
    @(negedge clk);
    in_valid = 1'b0;
    check_bit("R5", "b2b second chan", out_chan, 1'b0);
    check_addr("R13", "b2b second addr", out_chan_addr, 48'h10);
    check_bit("R13", "b2b second valid", out_valid, 1'b1);

    // R12 legal masks clear the error flag; mask 7 gives L=3 (R6 bit 15)
    @(negedge clk);
    load_preset(3);
    node_mask = 3'b111;
    node_id = 3'd0;
    sys_addr = 48'h8000;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_bit("R12", "mask7 no error", out_cfg_err, 1'b0);
    check_bit("R6", "mask7 chan bit15", out_chan, 1'b1);
    check_addr("R10", "mask7 addr", out_chan_addr, 48'h0);

    // R13 miss zeroes fields after a hit with nonzero outputs
    @(negedge clk);
    load_preset(7);
    sys_addr = 48'hD000_0000;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_bit("R2", "hole miss", out_hit, 1'b0);
    check_addr("R13", "miss zero addr", out_chan_addr, 48'h0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule